// File: doc/BRIEF.md
# Tear-free double-buffered frame store

This block places a camera image in the top-left corner of a larger display raster. The camera delivers 640x480 frames at about 125 frames per second. The display scans 1280x1024 at 60 Hz. The two sides run on unrelated clocks. The block uses two external frame memories. The camera writes one of them while the display reads the other. Every display pixel outside the camera window is black.

The block prevents tearing by controlling when the banks swap. A swap happens only at the start of a display frame, and only when the write bank already holds one whole camera frame. After a swap, the writer does not start partway through a camera frame. It waits for the next frame start, stores exactly one frame and then holds. Any further camera frames are dropped until the reader takes the finished bank. This works because the camera runs more than twice as fast as the display, so a complete frame is always ready before the reader needs it.

Two events cross between the clock domains: "frame stored" and "banks swapped". Each one travels as a toggle through a two-flop synchroniser. The receiving side turns the toggle back into a single pulse. Each memory bank is modelled as a synchronous two-port array. Its write side runs on the camera clock and its read side on the display clock. Read data returns one display clock after the read enable.

Top module: `dbl_frame_store`

## Requirements
- R1: After reset, no memory write or read enable is active, `dsp_pix_vld` is low, `dsp_pix` is zero, and both banks count as empty. The camera writes bank 1 first and the display is assigned bank 0.
- R2: Camera pixels that arrive before the first rising edge of `cam_vsync` after reset are not written.
- R3: A camera pixel is stored when `cam_valid` and `cam_hsync` are both high. Write addresses run from 0 to CAM_W*CAM_H-1 in raster order and restart at 0 on each rising edge of `cam_vsync`. Successive complete frames go to alternate banks, starting with bank 1, and never to the bank being read.
- R4: When the last address of a frame (CAM_W*CAM_H-1) has been written, the writer stops. Later camera frames produce no writes until the next bank swap.
- R5: On a `dsp_fstart` pulse, the banks swap only if a complete frame is waiting. Otherwise the display reads the same bank again and shows the same image. The read bank changes at no other time.
- R6: After a swap, the writer ignores the rest of any camera frame that is in progress. It starts writing again at the next rising edge of `cam_vsync`.
- R7: Display position and read address reset on `dsp_fstart`. Each `dsp_req` advances the position one pixel across DSP_W columns and then down one row. A request at column x < CAM_W and row y < CAM_H reads address y*CAM_W+x from the read bank. Any other request gives zero. `dsp_pix_vld` and `dsp_pix` present the result one display clock after the request.
- R8: The display output stays black until the first complete camera frame has been swapped in.
- R9: At most one bank write enable and at most one bank read enable is active in any cycle. Every enabled address is below CAM_W*CAM_H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cam_clk | input | 1 | Camera clock |
| cam_rst_n | input | 1 | Camera-domain reset, active low |
| cam_vsync | input | 1 | Camera frame sync; a rising edge starts a frame |
| cam_hsync | input | 1 | High during the active part of a camera line |
| cam_valid | input | 1 | Camera pixel strobe |
| cam_pix | input | PIX_W | Camera pixel value |
| dsp_clk | input | 1 | Display clock |
| dsp_rst_n | input | 1 | Display-domain reset, active low |
| dsp_fstart | input | 1 | One-cycle pulse before the first request of a display frame |
| dsp_req | input | 1 | Request for the next display pixel |
| dsp_pix_vld | output | 1 | Pixel result valid, one clock after `dsp_req` |
| dsp_pix | output | PIX_W | Display pixel; zero outside the camera window |
| mem_we | output | 2 | Write enable per bank (camera clock) |
| mem_waddr | output | ADDR_W | Shared write address |
| mem_wdata | output | PIX_W | Shared write data |
| mem_re | output | 2 | Read enable per bank (display clock) |
| mem_raddr | output | ADDR_W | Shared read address |
| mem_rdata0 | input | PIX_W | Bank 0 read data, one clock after read enable |
| mem_rdata1 | input | PIX_W | Bank 1 read data, one clock after read enable |

## Verification
Some properties are checked by assertions on every cycle:
- Bank enables are exclusive and addresses stay within the frame.
- The read bank changes only on a frame-start pulse.
- The output stays black while nothing has been swapped in.

The ordering rules can only be shown by scenarios that span both clock domains. These are: waiting for a frame start, holding after one frame, dropping a frame that is cut by a swap, and re-reading a bank when no new frame is ready. The bench checks them with a memory model, a write-sequence monitor and a pixel-by-pixel comparison of whole display frames.

// File: rtl/dbl_frame_store.sv
module dbl_frame_store #(
  parameter int CAM_W  = 640,
  parameter int CAM_H  = 480,
  parameter int DSP_W  = 1280,
  parameter int DSP_H  = 1024,
  parameter int PIX_W  = 16,
  parameter int ADDR_W = 19
) (
  input  logic              cam_clk,
  input  logic              cam_rst_n,
  input  logic              cam_vsync,
  input  logic              cam_hsync,
  input  logic              cam_valid,
  input  logic [PIX_W-1:0]  cam_pix,
  input  logic              dsp_clk,
  input  logic              dsp_rst_n,
  input  logic              dsp_fstart,
  input  logic              dsp_req,
  output logic              dsp_pix_vld,
  output logic [PIX_W-1:0]  dsp_pix,
  output logic [1:0]        mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [PIX_W-1:0]  mem_wdata,
  output logic [1:0]        mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [PIX_W-1:0]  mem_rdata0,
  input  logic [PIX_W-1:0]  mem_rdata1
);

  localparam int FRAME_PIX = CAM_W * CAM_H;
  localparam int XW = $clog2(DSP_W);
  localparam int YW = $clog2(DSP_H);
  localparam logic [ADDR_W-1:0] FRAME_LAST = ADDR_W'(FRAME_PIX - 1);
  localparam logic [XW-1:0]     X_LAST     = XW'(DSP_W - 1);

  typedef enum logic [1:0] {W_WAIT, W_FILL, W_HOLD} wst_t;

  // camera side
  wst_t              wst;
  logic              vs_q, wbank, done_tgl;
  logic [2:0]        swap_s;
  logic [ADDR_W-1:0] waddr;
  logic              swap_tgl;

  wire vs_rise  = cam_vsync & ~vs_q;
  wire swap_evt = swap_s[2] ^ swap_s[1];
  wire pix_ok   = (wst == W_FILL) & cam_valid & cam_hsync & ~vs_rise;

  assign mem_we    = {pix_ok & wbank, pix_ok & ~wbank};
  assign mem_waddr = waddr;
  assign mem_wdata = cam_pix;

  always_ff @(posedge cam_clk or negedge cam_rst_n) begin
    if (!cam_rst_n) begin
      vs_q     <= 1'b0;
      wst      <= W_WAIT;
      wbank    <= 1'b1;
      done_tgl <= 1'b0;
      swap_s   <= '0;
      waddr    <= '0;
    end else begin
      vs_q   <= cam_vsync;
      swap_s <= {swap_s[1:0], swap_tgl};
      if (swap_evt) begin
        wbank <= ~wbank;
        wst   <= W_WAIT;
      end else begin
        case (wst)
          W_WAIT: if (vs_rise) begin
            wst   <= W_FILL;
            waddr <= '0;
          end
          W_FILL: if (vs_rise) begin
            waddr <= '0;
          end else if (pix_ok) begin
            waddr <= waddr + 1'b1;
            if (waddr == FRAME_LAST) begin
              wst      <= W_HOLD;
              done_tgl <= ~done_tgl;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // display side
  logic              rbank, shown, ready, win_q, bank_q, vld_q;
  logic [2:0]        done_s;
  logic [XW-1:0]     x;
  logic [YW-1:0]     y;
  logic [ADDR_W-1:0] raddr;

  wire done_evt = done_s[2] ^ done_s[1];
  wire in_win   = (x < XW'(CAM_W)) & (y < YW'(CAM_H));
  wire rd       = dsp_req & in_win & shown;

  assign mem_re      = {rd & rbank, rd & ~rbank};
  assign mem_raddr   = raddr;
  assign dsp_pix_vld = vld_q;
  assign dsp_pix     = win_q ? (bank_q ? mem_rdata1 : mem_rdata0) : '0;

  always_ff @(posedge dsp_clk or negedge dsp_rst_n) begin
    if (!dsp_rst_n) begin
      rbank    <= 1'b0;
      shown    <= 1'b0;
      ready    <= 1'b0;
      swap_tgl <= 1'b0;
      done_s   <= '0;
      win_q    <= 1'b0;
      bank_q   <= 1'b0;
      vld_q    <= 1'b0;
      x        <= '0;
      y        <= '0;
      raddr    <= '0;
    end else begin
      done_s <= {done_s[1:0], done_tgl};
      vld_q  <= dsp_req;
      win_q  <= rd;
      bank_q <= rbank;
      if (done_evt) ready <= 1'b1;
      if (dsp_fstart) begin
        x     <= '0;
        y     <= '0;
        raddr <= '0;
        if (ready) begin
          rbank    <= ~rbank;
          shown    <= 1'b1;
          ready    <= 1'b0;
          swap_tgl <= ~swap_tgl;
        end
      end else if (dsp_req) begin
        if (x == X_LAST) begin
          x <= '0;
          y <= y + 1'b1;
        end else begin
          x <= x + 1'b1;
        end
        if (in_win) raddr <= raddr + 1'b1;
      end
    end
  end

  p_we_onehot_r9: assert property (@(posedge cam_clk) disable iff (!cam_rst_n)
    $onehot0(mem_we));
  p_waddr_range_r9: assert property (@(posedge cam_clk) disable iff (!cam_rst_n)
    (|mem_we) |-> (mem_waddr <= FRAME_LAST));
  p_re_onehot_r9: assert property (@(posedge dsp_clk) disable iff (!dsp_rst_n)
    $onehot0(mem_re));
  p_raddr_range_r7: assert property (@(posedge dsp_clk) disable iff (!dsp_rst_n)
    (|mem_re) |-> (mem_raddr <= FRAME_LAST));
  p_swap_at_fstart_r5: assert property (@(posedge dsp_clk) disable iff (!dsp_rst_n)
    !$stable(rbank) |-> $past(dsp_fstart));
  p_black_unshown_r8: assert property (@(posedge dsp_clk) disable iff (!dsp_rst_n)
    !shown |=> (dsp_pix == '0));

endmodule

// File: tb/dbl_frame_store_tb.sv
module dbl_frame_store_tb;
  localparam int CW = 4, CH = 2, DW = 6, DH = 3, PW = 16, AW = 19;
  localparam int FP = CW * CH;
  // columns: camera frames to send, first frame base, expect shown, expected base
  localparam int VEC [5][4] = '{
    '{0, 'h000, 0, 'h000},
    '{1, 'h100, 1, 'h100},
    '{0, 'h000, 1, 'h100},
    '{2, 'h200, 1, 'h200},
    '{1, 'h400, 1, 'h400}
  };

  logic cam_clk = 0, dsp_clk = 0, cam_rst_n = 0, dsp_rst_n = 0;
  logic cam_vsync = 0, cam_hsync = 0, cam_valid = 0;
  logic [PW-1:0] cam_pix = '0;
  logic dsp_fstart = 0, dsp_req = 0;
  logic dsp_pix_vld;
  logic [PW-1:0] dsp_pix, mem_wdata, rd0, rd1;
  logic [1:0] mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [PW-1:0] bank0 [FP];
  logic [PW-1:0] bank1 [FP];

  int n_chk = 0, n_fail = 0, wr_total = 0, wr_bad = 0;

  always #2.5 dsp_clk = ~dsp_clk;
  always #3.5 cam_clk = ~cam_clk;

  dbl_frame_store #(.CAM_W(CW), .CAM_H(CH), .DSP_W(DW), .DSP_H(DH),
                    .PIX_W(PW), .ADDR_W(AW)) u_dut (
    .cam_clk(cam_clk), .cam_rst_n(cam_rst_n), .cam_vsync(cam_vsync),
    .cam_hsync(cam_hsync), .cam_valid(cam_valid), .cam_pix(cam_pix),
    .dsp_clk(dsp_clk), .dsp_rst_n(dsp_rst_n), .dsp_fstart(dsp_fstart),
    .dsp_req(dsp_req), .dsp_pix_vld(dsp_pix_vld), .dsp_pix(dsp_pix),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata0(rd0), .mem_rdata1(rd1));

  // memory model and write-sequence monitor (R3)
  always @(posedge cam_clk) begin
    if (cam_rst_n && (|mem_we)) begin
      int ea;
      int eb;
      ea = wr_total % FP;
      eb = ((wr_total / FP) % 2 == 0) ? 1 : 0;
      if (int'(mem_waddr) != ea || mem_we[eb] != 1'b1) wr_bad++;
      if (mem_waddr < AW'(FP)) begin
        if (mem_we[0]) bank0[mem_waddr] <= mem_wdata;
        if (mem_we[1]) bank1[mem_waddr] <= mem_wdata;
      end
      wr_total++;
    end
  end

  always @(posedge dsp_clk) begin
    if (mem_re[0] && mem_raddr < AW'(FP)) rd0 <= bank0[mem_raddr];
    if (mem_re[1] && mem_raddr < AW'(FP)) rd1 <= bank1[mem_raddr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cam_frame(input int base, input int idle);
    int idx = 0;
    @(negedge cam_clk) cam_vsync = 1;
    repeat (2) @(negedge cam_clk);
    cam_vsync = 0;
    @(negedge cam_clk);
    for (int yy = 0; yy < CH; yy++) begin
      cam_hsync = 1;
      for (int xx = 0; xx < CW; xx++) begin
        cam_valid = 1;
        cam_pix = PW'(base + idx);
        idx++;
        @(negedge cam_clk);
        cam_valid = 0;
        repeat (idle) @(negedge cam_clk);
      end
      cam_hsync = 0;
      repeat (2) @(negedge cam_clk);
    end
  endtask

  task automatic dsp_frame(input int shown, input int base);
    @(negedge dsp_clk) dsp_fstart = 1;
    @(negedge dsp_clk) dsp_fstart = 0;
    @(negedge dsp_clk);
    for (int yy = 0; yy < DH; yy++) begin
      for (int xx = 0; xx < DW; xx++) begin
        int exp;
        bit win;
        win = (xx < CW) && (yy < CH);
        exp = (win && shown != 0) ? ((base + yy * CW + xx) & 'hFFFF) : 0;
        dsp_req = 1;
        @(negedge dsp_clk);
        dsp_req = 0;
        chk(dsp_pix_vld == 1'b1, "R7", int'(dsp_pix_vld), 1);
        chk(int'(dsp_pix) == exp, (shown != 0) ? "R7" : "R8", int'(dsp_pix), exp);
        @(negedge dsp_clk);
      end
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge dsp_clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int w0;
    repeat (4) @(negedge cam_clk);
    cam_rst_n = 1;
    dsp_rst_n = 1;
    @(negedge dsp_clk);
    // R1 reset state
    chk(dsp_pix == '0, "R1", int'(dsp_pix), 0);
    chk(dsp_pix_vld == 1'b0, "R1", int'(dsp_pix_vld), 0);
    chk(mem_we == 2'b00, "R1", int'(mem_we), 0);
    chk(mem_re == 2'b00, "R1", int'(mem_re), 0);

    // R2: pixels without a frame start are not stored
    @(negedge cam_clk);
    cam_hsync = 1;
    for (int i = 0; i < 10; i++) begin
      cam_valid = 1;
      cam_pix = PW'(16'hEE00 + i);
      @(negedge cam_clk);
    end
    cam_valid = 0;
    cam_hsync = 0;
    repeat (3) @(negedge cam_clk);
    chk(wr_total == 0, "R2", wr_total, 0);

    // vector table: R4, R5, R8
    for (int i = 0; i < 5; i++) begin
      w0 = wr_total;
      for (int k = 0; k < VEC[i][0]; k++) cam_frame(VEC[i][1] + k * 'h100, 0);
      repeat (20) @(negedge dsp_clk);
      chk(wr_total - w0 == ((VEC[i][0] > 0) ? FP : 0), "R4",
          wr_total - w0, (VEC[i][0] > 0) ? FP : 0);
      dsp_frame(VEC[i][2], VEC[i][3]);
      repeat (20) @(negedge cam_clk);
    end

    // R6: swap arrives in the middle of a camera frame
    w0 = wr_total;
    cam_frame('h500, 0);
    repeat (20) @(negedge dsp_clk);
    chk(wr_total - w0 == FP, "R6", wr_total - w0, FP);
    w0 = wr_total;
    fork
      cam_frame('h600, 6);
      begin
        repeat (10) @(negedge cam_clk);
        dsp_frame(1, 'h500);
      end
    join
    chk(wr_total == w0, "R6", wr_total - w0, 0);
    repeat (20) @(negedge cam_clk);
    w0 = wr_total;
    cam_frame('h700, 0);
    repeat (20) @(negedge dsp_clk);
    chk(wr_total - w0 == FP, "R6", wr_total - w0, FP);
    dsp_frame(1, 'h700);

    // R3: raster addresses and bank alternation of every write
    chk(wr_bad == 0, "R3", wr_bad, 0);
    chk(wr_total == 5 * FP, "R3", wr_total, 5 * FP);
    finish_run();
  end
endmodule